// File: doc/BRIEF.md
# Partitioned Saturating SIMD Adder

This block adds two 32-bit operands either as one full word or as two independent 16-bit lanes packed side by side. In lane mode the carry chain is broken between the halves, so each lane behaves as its own 16-bit adder. Every lane, and the full word in word mode, can either wrap around on overflow or clamp to the extreme value of its number range. Operands can be read as unsigned or as two's complement.

An averaging option returns half of the sum. Two variants are offered. The exact variant keeps the carry as an extra bit before it shifts, so the result is the true floor of (a+b)/2. The clipped variant shifts the 16-bit (or 32-bit) lane result, wrapped or clamped, and so shows what is lost when the full sum is not kept. Overflow is reported on per-lane flags only. Nothing else in the block reacts to it.

The datapath is combinational and is followed by an optional output register, which is on by default.

Top module: `psat_adder`

## Requirements
- R1: While `rst_n` is low, `result` and `ovf` read 0. With the default output register, every output reflects the inputs sampled at the previous rising clock edge.
- R2: With `split`=1, bits [15:0] and [31:16] are computed independently. No carry passes from bit 15 into bit 16. For example, unsigned 0x0000FFFF + 0x00000001 with wrap gives 0x00000000 and `ovf`=2'b01.
- R3: With `split`=0, the operands are added as one 32-bit word with full carry propagation. The word's overflow appears on `ovf[0]`, and `ovf[1]` is 0.
- R4: With `sgn`=0 and `sat_en`=1, a sum above the unsigned maximum returns all ones (0xFFFF per lane, 0xFFFFFFFF per word). With `sat_en`=0, the sum wraps modulo 2^width.
- R5: With `sgn`=1 and `sat_en`=1, a positive overflow returns 0x7FFF (0x7FFFFFFF in word mode) and a negative overflow returns 0x8000 (0x80000000).
- R6: An overflow flag is 1 exactly when the lane's (or word's) true sum lies outside its representable range for the chosen signedness. This holds whatever `sat_en`, `halve_en` and `halve_clip` are. The flag has no other effect.
- R7: With `halve_en`=1 and `halve_clip`=0, each lane returns floor((a+b)/2) of the true sum, with the carry kept as the extra top bit. Example: unsigned 0x7FFF + 0x8001 gives 0x8000.
- R8: With `halve_en`=1 and `halve_clip`=1, each lane returns its non-halved result (wrapped or clamped, as `sat_en` selects) shifted right by one. The shift is logical for unsigned and arithmetic for signed. Example: unsigned 0x7FFF + 0x8001 gives 0x0000 with wrap and 0x7FFF with saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset that clears the output register |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| split | input | 1 | 1: two 16-bit lanes, 0: one 32-bit word |
| sgn | input | 1 | 1: two's complement operands, 0: unsigned |
| sat_en | input | 1 | 1: clamp on overflow, 0: wrap |
| halve_en | input | 1 | 1: return half of the sum |
| halve_clip | input | 1 | With halve_en: 1 shifts the wrapped or clamped result, 0 shifts the exact sum |
| result | output | 32 | Sum, clamped sum or halved sum |
| ovf | output | 2 | Per-lane overflow flags (word mode uses bit 0) |

## Verification
The scaled form of the worked 4-bit example (0x7FFF + 0x8001 unsigned) is applied under wrap, saturation, exact halving and clipped halving. This example alone tells all four result paths apart. Operands that carry out of bit 15 show whether the lane boundary really cuts the carry, because lane mode and word mode must then disagree. Signed operands at ±full scale test the upper and lower clamp limits separately. Random operands are biased toward these edges and are run under random control combinations. The random runs check that the flags follow the true range under every control setting and never follow the clamped or halved value.

// File: rtl/psa_pkg.sv
package psa_pkg;
  localparam int LANE_W = 16;
  localparam int LANES  = 2;

  // Per-lane control bundle shared by every post-processing stage.
  typedef struct packed {
    logic sgn;    // two's complement operands
    logic sat;    // clamp on overflow
    logic halve;  // return half the sum
    logic clip;   // halve the wrapped/clamped value instead of the exact sum
  } lane_ctl_t;
endpackage

// File: rtl/psa_lane_adder.sv
module psa_lane_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         c_msb   // carry into the top bit, needed for signed overflow
);
  localparam int LOW_W = W - 1;

  function automatic logic [LOW_W:0] add_low(input logic [LOW_W-1:0] x,
                                             input logic [LOW_W-1:0] y,
                                             input logic             ci);
    return {1'b0, x} + {1'b0, y} + {{LOW_W{1'b0}}, ci};
  endfunction

  logic [LOW_W:0] low_sum;
  logic [1:0]     top_sum;

  always_comb begin
    low_sum = add_low(a[LOW_W-1:0], b[LOW_W-1:0], cin);
    c_msb   = low_sum[LOW_W];
    top_sum = {1'b0, a[W-1]} + {1'b0, b[W-1]} + {1'b0, c_msb};
    sum     = {top_sum[0], low_sum[LOW_W-1:0]};
    cout    = top_sum[1];
  end
endmodule

// File: rtl/psa_lane_post.sv
module psa_lane_post
  import psa_pkg::*;
#(
  parameter int W = 16
) (
  input  lane_ctl_t    ctl,
  input  logic [W-1:0] sum,
  input  logic         cout,
  input  logic         c_msb,
  output logic [W-1:0] res,
  output logic         ovf,
  output logic         clamp_hit
);
  // Extreme value of the range; neg selects the lower limit for signed.
  function automatic logic [W-1:0] clamp_val(input logic sgn, input logic neg);
    if (!sgn)     return {W{1'b1}};
    else if (neg) return {1'b1, {(W-1){1'b0}}};
    else          return {1'b0, {(W-1){1'b1}}};
  endfunction

  // Bit W of the true (W+1)-bit sum.
  function automatic logic true_top(input logic sgn, input logic msb,
                                    input logic ov, input logic co);
    return sgn ? (msb ^ ov) : co;
  endfunction

  logic         top_bit;
  logic [W-1:0] base;

  always_comb begin
    ovf       = ctl.sgn ? (cout ^ c_msb) : cout;
    top_bit   = true_top(ctl.sgn, sum[W-1], ovf, cout);
    clamp_hit = ctl.sat & ovf;
    base      = clamp_hit ? clamp_val(ctl.sgn, top_bit) : sum;
    if (!ctl.halve)    res = base;
    else if (ctl.clip) res = {ctl.sgn & base[W-1], base[W-1:1]};
    else               res = {top_bit, sum[W-1:1]};
  end
endmodule

// File: rtl/psat_adder.sv
module psat_adder
  import psa_pkg::*;
#(
  parameter int LANE_BITS = LANE_W,
  parameter int NLANES    = LANES,
  parameter bit OUT_REG   = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [LANE_BITS*NLANES-1:0] a,
  input  logic [LANE_BITS*NLANES-1:0] b,
  input  logic                        split,
  input  logic                        sgn,
  input  logic                        sat_en,
  input  logic                        halve_en,
  input  logic                        halve_clip,
  output logic [LANE_BITS*NLANES-1:0] result,
  output logic [NLANES-1:0]           ovf
);
  localparam int WORD_W = LANE_BITS * NLANES;
  localparam int HI_LO  = WORD_W - LANE_BITS;

  lane_ctl_t ctl;
  assign ctl = '{sgn: sgn, sat: sat_en, halve: halve_en, clip: halve_clip};

  // Named internal events for the assertions.
  logic [NLANES-1:0]  carry_into;
  logic [NLANES-1:0]  lane_cout;
  logic [NLANES-1:0]  lane_cmsb;
  logic [NLANES-1:0]  lane_ovf;
  logic [NLANES-1:0]  lane_clamp;
  logic [WORD_W-1:0]  raw_sum;
  logic [WORD_W-1:0]  lane_res;
  logic [WORD_W-1:0]  word_res;
  logic               word_ovf;
  logic               word_clamp;
  logic [WORD_W-1:0]  nxt_res;
  logic [NLANES-1:0]  nxt_ovf;

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    if (i == 0) begin : g_first
      assign carry_into[i] = 1'b0;
    end else begin : g_chain
      assign carry_into[i] = split ? 1'b0 : lane_cout[i-1];
    end

    psa_lane_adder #(.W(LANE_BITS)) u_add (
      .a     (a[i*LANE_BITS +: LANE_BITS]),
      .b     (b[i*LANE_BITS +: LANE_BITS]),
      .cin   (carry_into[i]),
      .sum   (raw_sum[i*LANE_BITS +: LANE_BITS]),
      .cout  (lane_cout[i]),
      .c_msb (lane_cmsb[i])
    );

    psa_lane_post #(.W(LANE_BITS)) u_post (
      .ctl       (ctl),
      .sum       (raw_sum[i*LANE_BITS +: LANE_BITS]),
      .cout      (lane_cout[i]),
      .c_msb     (lane_cmsb[i]),
      .res       (lane_res[i*LANE_BITS +: LANE_BITS]),
      .ovf       (lane_ovf[i]),
      .clamp_hit (lane_clamp[i])
    );
  end

  // Whole-word post stage: valid when the chain is unbroken (split = 0).
  psa_lane_post #(.W(WORD_W)) u_word_post (
    .ctl       (ctl),
    .sum       (raw_sum),
    .cout      (lane_cout[NLANES-1]),
    .c_msb     (lane_cmsb[NLANES-1]),
    .res       (word_res),
    .ovf       (word_ovf),
    .clamp_hit (word_clamp)
  );

  always_comb begin
    if (split) begin
      nxt_res = lane_res;
      nxt_ovf = lane_ovf;
    end else begin
      nxt_res = word_res;
      nxt_ovf = {{(NLANES-1){1'b0}}, word_ovf};
    end
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        result <= '0;
        ovf    <= '0;
      end else begin
        result <= nxt_res;
        ovf    <= nxt_ovf;
      end
    end

    // R1: registered stage carries the combinational value one cycle later
    a_r1_reg_stage: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (result == $past(nxt_res)) && (ovf == $past(nxt_ovf)));
  end else begin : g_comb
    assign result = nxt_res;
    assign ovf    = nxt_ovf;
  end

  // Independent references for the checks below.
  logic [LANE_BITS-1:0] hi_wrap;
  logic [WORD_W-1:0]    word_wrap;
  assign hi_wrap   = a[WORD_W-1 -: LANE_BITS] + b[WORD_W-1 -: LANE_BITS];
  assign word_wrap = a + b;

  // R2: upper lane ignores the lower lane's carry in lane mode
  a_r2_lane_carry_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (split && !sat_en && !halve_en) |-> (nxt_res[WORD_W-1:HI_LO] == hi_wrap));

  // R3: word mode is a plain full-width add when nothing else is selected
  a_r3_word_add: assert property (@(posedge clk) disable iff (!rst_n)
    (!split && !sat_en && !halve_en) |-> (nxt_res == word_wrap));

  // R4: unsigned saturating lane result never falls below either operand
  a_r4_sat_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (split && sat_en && !sgn && !halve_en) |->
      (nxt_res[LANE_BITS-1:0] >= a[LANE_BITS-1:0]) &&
      (nxt_res[LANE_BITS-1:0] >= b[LANE_BITS-1:0]));

  // R6: an unsigned lane flag means the wrapped sum dropped below the operand
  a_r6_flag_means_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (split && !sgn && !sat_en && !halve_en) |->
      (nxt_ovf[0] == (nxt_res[LANE_BITS-1:0] < a[LANE_BITS-1:0])));

  // R5: a clamp only ever happens while saturation is enabled
  a_r5_clamp_needs_sat: assert property (@(posedge clk) disable iff (!rst_n)
    ((|lane_clamp) || word_clamp) |-> sat_en);

  // R7: exact unsigned average lies between the two operands
  a_r7_exact_mean_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (split && halve_en && !halve_clip && !sgn) |->
      ((nxt_res[LANE_BITS-1:0] >= a[LANE_BITS-1:0]) ||
       (nxt_res[LANE_BITS-1:0] >= b[LANE_BITS-1:0])) &&
      ((nxt_res[LANE_BITS-1:0] <= a[LANE_BITS-1:0]) ||
       (nxt_res[LANE_BITS-1:0] <= b[LANE_BITS-1:0])));

  // R8: unsigned clipped halving always clears the top bit of a lane
  a_r8_clip_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (split && halve_en && halve_clip && !sgn) |->
      (!nxt_res[LANE_BITS-1] && !nxt_res[WORD_W-1]));
endmodule

// File: tb/psat_adder_test.sv
module psat_adder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        split = 1'b0, sgn = 1'b0, sat_en = 1'b0;
  logic        halve_en = 1'b0, halve_clip = 1'b0;
  logic [31:0] result;
  logic [1:0]  ovf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  psat_adder uut (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .split(split), .sgn(sgn),
    .sat_en(sat_en), .halve_en(halve_en), .halve_clip(halve_clip),
    .result(result), .ovf(ovf)
  );

  // Returns {ovf, result bits} for one lane of width w, from the requirements.
  function automatic logic [32:0] ref_lane(input int w, input logic [31:0] x,
      input logic [31:0] y, input logic s, input logic sat, input logic hv,
      input logic cl);
    longint mask, xv, yv, sum, lo, hi, base, bb, r;
    logic   ov;
    mask = (64'sd1 <<< w) - 1;
    xv = longint'(x) & mask;
    yv = longint'(y) & mask;
    if (s) begin
      if (xv >= (64'sd1 <<< (w-1))) xv = xv - (64'sd1 <<< w);
      if (yv >= (64'sd1 <<< (w-1))) yv = yv - (64'sd1 <<< w);
      lo = -(64'sd1 <<< (w-1));
      hi = (64'sd1 <<< (w-1)) - 1;
    end else begin
      lo = 0;
      hi = mask;
    end
    sum = xv + yv;
    ov = (sum < lo) || (sum > hi);
    base = (ov && sat) ? ((sum > hi) ? hi : lo) : sum;
    bb = base & mask;
    if (!hv) r = bb;
    else if (!cl) r = sum >>> 1;
    else begin
      if (s && bb >= (64'sd1 <<< (w-1))) bb = bb - (64'sd1 <<< w);
      r = bb >>> 1;
    end
    return {ov, 32'(r & mask)};
  endfunction

  function automatic logic [33:0] ref_all(input logic [31:0] x, input logic [31:0] y,
      input logic sp, input logic s, input logic sat, input logic hv, input logic cl);
    logic [32:0] l0, l1, w;
    if (sp) begin
      l0 = ref_lane(16, x, y, s, sat, hv, cl);
      l1 = ref_lane(16, x >> 16, y >> 16, s, sat, hv, cl);
      return {l1[32], l0[32], l1[15:0], l0[15:0]};
    end
    w = ref_lane(32, x, y, s, sat, hv, cl);
    return {1'b0, w[32], w[31:0]};
  endfunction

  task automatic apply(input logic [31:0] x, input logic [31:0] y, input logic sp,
      input logic s, input logic sat, input logic hv, input logic cl, input string tag);
    logic [33:0] exp;
    @(negedge clk);
    a = x; b = y; split = sp; sgn = s; sat_en = sat; halve_en = hv; halve_clip = cl;
    exp = ref_all(x, y, sp, s, sat, hv, cl);
    @(posedge clk);
    #1;
    checks++;
    if (result !== exp[31:0]) begin
      errors++;
      $display("FAIL %s result a=%h b=%h ctl=%b%b%b%b%b actual=%h expected=%h",
               tag, x, y, sp, s, sat, hv, cl, result, exp[31:0]);
    end
    checks++;
    if (ovf !== exp[33:32]) begin
      errors++;
      $display("FAIL R6 ovf a=%h b=%h ctl=%b%b%b%b%b actual=%b expected=%b",
               x, y, sp, s, sat, hv, cl, ovf, exp[33:32]);
    end
  endtask

  task automatic expect_val(input logic [31:0] got, input logic [31:0] want, input string tag);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, want);
    end
  endtask

  function automatic logic [31:0] pick_op();
    case ($urandom_range(0, 7))
      0: return 32'h7FFF_7FFF;
      1: return 32'h8000_8000;
      2: return 32'hFFFF_FFFF;
      3: return {16'($urandom), 16'hFFFF};
      4: return 32'h0000_0001;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(2_000_000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    a = 32'h1234_5678; b = 32'h9ABC_DEF0; split = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: held in reset
    expect_val(result, 32'h0, "R1 reset result");
    expect_val({30'h0, ovf}, 32'h0, "R1 reset ovf");
    @(negedge clk);
    rst_n = 1'b1;

    // R7 / R8 / R4: scaled worked example
    apply(32'h7FFF_7FFF, 32'h8001_8001, 1, 0, 0, 0, 0, "R4 wrap");
    apply(32'h7FFF_7FFF, 32'h8001_8001, 1, 0, 1, 0, 0, "R4 sat");
    apply(32'h7FFF_7FFF, 32'h8001_8001, 1, 0, 0, 1, 0, "R7 exact");
    expect_val(result, 32'h8000_8000, "R7 exact value");
    apply(32'h7FFF_7FFF, 32'h8001_8001, 1, 0, 0, 1, 1, "R8 wrap-shift");
    expect_val(result, 32'h0000_0000, "R8 wrap-shift value");
    apply(32'h7FFF_7FFF, 32'h8001_8001, 1, 0, 1, 1, 1, "R8 sat-shift");
    expect_val(result, 32'h7FFF_7FFF, "R8 sat-shift value");

    // R2 / R3: carry cut versus full carry
    apply(32'h0000_FFFF, 32'h0000_0001, 1, 0, 0, 0, 0, "R2 carry cut");
    expect_val(result, 32'h0000_0000, "R2 cut value");
    apply(32'h0000_FFFF, 32'h0000_0001, 0, 0, 0, 0, 0, "R3 carry through");
    expect_val(result, 32'h0001_0000, "R3 word value");
    apply(32'hFFFF_FFFF, 32'h0000_0001, 0, 0, 0, 0, 0, "R3 word wrap");
    expect_val({30'h0, ovf}, 32'h1, "R3 word flag on bit 0");

    // R5: signed limits, lane and word
    apply(32'h7FFF_8000, 32'h0001_FFFF, 1, 1, 1, 0, 0, "R5 lane limits");
    expect_val(result, 32'h7FFF_8000, "R5 lane clamp value");
    apply(32'h7FFF_FFFF, 32'h0000_0001, 0, 1, 1, 0, 0, "R5 word max");
    apply(32'h8000_0000, 32'hFFFF_FFFF, 0, 1, 1, 0, 0, "R5 word min");
    apply(32'h8000_8000, 32'h8000_8000, 1, 1, 0, 1, 0, "R7 signed exact");
    apply(32'h8000_7FFF, 32'h8000_7FFF, 1, 1, 1, 1, 1, "R8 signed clip");

    for (int n = 0; n < 4000; n++) begin
      logic sp, s, sat, hv, cl;
      string tag;
      sp = 1'($urandom); s = 1'($urandom); sat = 1'($urandom);
      hv = 1'($urandom); cl = 1'($urandom);
      if (hv) tag = cl ? "R8" : "R7";
      else if (sat) tag = s ? "R5" : "R4";
      else tag = sp ? "R2" : "R3";
      apply(pick_op(), pick_op(), sp, s, sat, hv, cl, tag);
    end

    // R1: reset clears again mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    expect_val(result, 32'h0, "R1 async reset");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule